// File: doc/BRIEF.md
# USB Device Event Status Unit

This unit collects the device-level events that a USB device controller reports to its processor, and it drives the processor's interrupt line for them. The packet and line-state logic upstream delivers one-cycle pulses: suspend entry, start-of-frame with its frame number, bus reset, host-driven resume, setup-stage reception and a successful SetConfiguration with its configuration number. Each pulse sets a sticky flag. Software reads the flags through a small register port and acknowledges each one by writing 0 to it.

A second register holds the interrupt enables and a read-only copy of the last configuration number. A third register holds the frame number of the most recent start-of-frame. The interrupt request is the OR of every enabled interrupt-capable flag. The setup flag never takes part in it. A host resume is not recorded while the local remote-wakeup request is asserted.

Top module: `usb_evt_status`

## Requirements
- R1: After reset, the status register (select 0), the enable register (select 1) and the timestamp register (select 2) all read 0, and `irq` is 0.
- R2: Each event pulse sets its own flag in the status register: suspend at bit 5, start-of-frame at bit 4, bus reset at bit 3, host wake-up at bit 2, setup at bit 1 and configuration at bit 0. Bits 15:6 of select 0 read 0.
- R3: In a status write, a 0 clears the flag at that position and a 1 leaves it unchanged. Writing back a value that was just read therefore keeps every flag that was set.
- R4: When an event sets a flag in the same cycle that software clears it, the flag ends up set.
- R5: A start-of-frame pulse loads `ev_frame` into bits 10:0 of select 2. Writes to select 2 have no effect.
- R6: The wake-up flag is set only by `ev_host_resume`, and only while `local_resume_req` is 0.
- R7: The setup flag never asserts `irq`, whatever the enables hold.
- R8: The enable register holds the suspend enable at bit 13, the start-of-frame enable at bit 12, the bus-reset enable at bit 11, the wake-up enable at bit 10 and the configuration enable at bit 8. Bits 15:14 and 7:0 always read 0.
- R9: Bit 9 of the enable register shows the configuration number. Software writes do not change it. It is loaded from `ev_config_num` in the same cycle that the configuration flag is set.
- R10: `irq` is 1 exactly when some flag among suspend, start-of-frame, bus reset, wake-up and configuration is set and its enable is 1. A flag that was set while disabled raises `irq` in the first cycle after its enable is written to 1.
- R11: A status write takes effect only when `reg_be[0]` is 1. An enable-register write takes effect only when `reg_be[1]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 status, 1 enable, 2 timestamp |
| reg_we | input | 1 | Write strobe |
| reg_be | input | 2 | Byte enables for bits 7:0 and 15:8 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| ev_suspend | input | 1 | Suspend entry pulse |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_frame | input | FRAME_W | Frame number that comes with `ev_sof` |
| ev_bus_reset | input | 1 | Bus reset pulse |
| ev_host_resume | input | 1 | Resume pulse driven by the host |
| ev_setup | input | 1 | Setup stage received pulse |
| ev_set_config | input | 1 | SetConfiguration accepted pulse |
| ev_config_num | input | 1 | Configuration number that comes with `ev_set_config` |
| local_resume_req | input | 1 | Local remote-wakeup request level |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the unit with the default `FRAME_W` of 11. This makes the all-ones frame number 0x7FF reachable, so the upper bits of the timestamp field are checked against the 0 that lies above it. With the 16-bit port, every reserved bit of each register shows up on the read data. Those bits are compared with 0 after writes of all ones.

// File: rtl/usb_evt_status.sv
`timescale 1ns/1ps
module usb_evt_status #(
  parameter int FRAME_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         reg_sel,
  input  logic               reg_we,
  input  logic [1:0]         reg_be,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               ev_suspend,
  input  logic               ev_sof,
  input  logic [FRAME_W-1:0] ev_frame,
  input  logic               ev_bus_reset,
  input  logic               ev_host_resume,
  input  logic               ev_setup,
  input  logic               ev_set_config,
  input  logic               ev_config_num,
  input  logic               local_resume_req,
  output logic               irq
);
  localparam int PAD_W = 16 - FRAME_W;

  logic [5:0]         flags;
  logic [4:0]         int_en;
  logic               cfg_num;
  logic [FRAME_W-1:0] tstamp;

  wire st_wr = reg_we && (reg_sel == 2'd0) && reg_be[0];
  wire en_wr = reg_we && (reg_sel == 2'd1) && reg_be[1];

  wire [5:0] hw_set = {ev_suspend, ev_sof, ev_bus_reset,
                       ev_host_resume & ~local_resume_req,
                       ev_setup, ev_set_config};
  wire [5:0] kept   = st_wr ? (flags & reg_wdata[5:0]) : flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      int_en  <= '0;
      cfg_num <= 1'b0;
      tstamp  <= '0;
    end else begin
      flags <= kept | hw_set;
      if (en_wr)         int_en  <= {reg_wdata[13:10], reg_wdata[8]};
      if (ev_set_config) cfg_num <= ev_config_num;
      if (ev_sof)        tstamp  <= ev_frame;
    end
  end

  assign irq = |({flags[5:2], flags[0]} & int_en);

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {10'd0, flags};
      2'd1:    reg_rdata = {2'b00, int_en[4:1], cfg_num, int_en[0], 8'd0};
      2'd2:    reg_rdata = {{PAD_W{1'b0}}, tstamp};
      default: reg_rdata = 16'd0;
    endcase
  end
endmodule

// File: rtl/usb_evt_status_chk.sv
`timescale 1ns/1ps
module usb_evt_status_chk #(
  parameter int FRAME_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_sof,
  input logic [FRAME_W-1:0] ev_frame,
  input logic               ev_bus_reset,
  input logic               ev_host_resume,
  input logic               ev_setup,
  input logic               ev_set_config,
  input logic               local_resume_req,
  input logic [5:0]         flags,
  input logic [4:0]         int_en,
  input logic               cfg_num,
  input logic [FRAME_W-1:0] tstamp,
  input logic               irq
);
  // R5
  sof_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |=> (tstamp == $past(ev_frame)) && flags[4]);
  // R4
  brst_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_reset |=> flags[3]);
  // R6
  wkup_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(ev_host_resume && !local_resume_req));
  // R2
  setp_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(ev_setup));
  // R7
  setp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & 6'b111101) == 6'd0) |-> !irq);
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_set_config |=> $stable(cfg_num));
  // R10
  brst_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[3] && int_en[2]) |-> irq);
endmodule

bind usb_evt_status usb_evt_status_chk #(.FRAME_W(FRAME_W)) u_chk (.*);

// File: tb/sim_usb_evt_status.sv
`timescale 1ns/1ps
module sim_usb_evt_status;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic reg_we = 0;
  logic [1:0] reg_be = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic ev_suspend = 0, ev_sof = 0, ev_bus_reset = 0, ev_host_resume = 0;
  logic ev_setup = 0, ev_set_config = 0, ev_config_num = 0, local_resume_req = 0;
  logic [10:0] ev_frame = 0;
  logic irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  usb_evt_status u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; reg_be = be; reg_wdata = d; reg_we = 1;
    @(negedge clk);
    reg_we = 0; reg_be = 0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  // event vector order: suspend, sof, bus_reset, host_resume, setup, set_config
  task automatic fire(input logic [5:0] m, input logic [10:0] fr, input logic cn);
    @(negedge clk);
    {ev_suspend, ev_sof, ev_bus_reset, ev_host_resume, ev_setup, ev_set_config} = m;
    ev_frame = fr; ev_config_num = cn;
    @(negedge clk);
    {ev_suspend, ev_sof, ev_bus_reset, ev_host_resume, ev_setup, ev_set_config} = '0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    rd(0, d); chk("R1 status", d, 0);
    rd(1, d); chk("R1 enable", d, 0);
    rd(2, d); chk("R1 tstamp", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_flags;
    logic [15:0] d;
    for (int i = 0; i < 6; i++) begin
      wr(0, 2'b01, 0);
      fire(6'b1 << i, 0, 0);
      rd(0, d); chk("R2 flag position", d, 16'(1 << i));
    end
  endtask

  task automatic t_clear;
    logic [15:0] d;
    wr(0, 2'b01, 0);
    fire(6'b101011, 0, 0);
    rd(0, d); wr(0, 2'b01, d);
    rd(0, d); chk("R3 writeback keeps", d, 16'h002B);
    wr(0, 2'b01, 16'hFFF7);
    rd(0, d); chk("R3 zero clears one", d, 16'h0023);
    wr(0, 2'b01, 0);
    wr(0, 2'b01, 16'hFFFF);
    rd(0, d); chk("R3 one does not set", d, 0);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    fire(6'b001000, 0, 0);
    @(negedge clk);
    ev_bus_reset = 1; reg_sel = 0; reg_be = 2'b01; reg_wdata = 0; reg_we = 1;
    @(negedge clk);
    ev_bus_reset = 0; reg_we = 0; reg_be = 0;
    rd(0, d); chk("R4 set beats clear", d, 16'h0008);
    wr(0, 2'b01, 0);
  endtask

  task automatic t_sof;
    logic [15:0] d;
    fire(6'b010000, 11'h7FF, 0);
    rd(2, d); chk("R5 tstamp max", d, 16'h07FF);
    fire(6'b010000, 11'h2A5, 0);
    rd(2, d); chk("R5 tstamp load", d, 16'h02A5);
    wr(2, 2'b11, 16'h0000);
    rd(2, d); chk("R5 tstamp not writable", d, 16'h02A5);
    wr(0, 2'b01, 0);
  endtask

  task automatic t_wkup;
    logic [15:0] d;
    local_resume_req = 1;
    fire(6'b000100, 0, 0);
    rd(0, d); chk("R6 blocked by local resume", d, 0);
    local_resume_req = 0;
    fire(6'b000100, 0, 0);
    rd(0, d); chk("R6 host resume sets", d, 16'h0004);
    wr(0, 2'b01, 0);
  endtask

  task automatic t_layout;
    logic [15:0] d;
    wr(1, 2'b11, 16'hFFFF);
    rd(1, d); chk("R8 enable layout", d, 16'h3D00);
    wr(1, 2'b11, 0);
  endtask

  task automatic t_cfg;
    logic [15:0] d;
    fire(6'b000001, 0, 1);
    rd(1, d); chk("R9 cfg number loaded", d, 16'h0200);
    wr(1, 2'b11, 16'h0000);
    rd(1, d); chk("R9 cfg number read-only", d, 16'h0200);
    fire(6'b000001, 0, 0);
    rd(1, d); chk("R9 cfg number back to 0", d, 0);
    wr(0, 2'b01, 0);
  endtask

  task automatic t_setp_irq;
    wr(1, 2'b10, 16'hFFFF);
    fire(6'b000010, 0, 0);
    chk("R7 setup gives no irq", irq, 0);
    wr(0, 2'b01, 0);
    wr(1, 2'b10, 0);
  endtask

  task automatic t_irq;
    fire(6'b100000, 0, 0);
    chk("R10 disabled flag no irq", irq, 0);
    wr(1, 2'b10, 16'h2000);
    chk("R10 late enable raises irq", irq, 1);
    wr(0, 2'b01, 16'hFFDF);
    chk("R10 clear drops irq", irq, 0);
    wr(1, 2'b10, 16'h0100);
    fire(6'b000001, 0, 0);
    chk("R10 conf irq", irq, 1);
    wr(0, 2'b01, 0);
    wr(1, 2'b10, 0);
  endtask

  task automatic t_be;
    logic [15:0] d;
    fire(6'b001000, 0, 0);
    wr(0, 2'b10, 0);
    rd(0, d); chk("R11 status needs be0", d, 16'h0008);
    wr(1, 2'b01, 16'hFFFF);
    rd(1, d); chk("R11 enable needs be1", d, 0);
    wr(0, 2'b01, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_flags; t_clear; t_collide; t_sof; t_wkup;
    t_layout; t_cfg; t_setp_irq; t_irq; t_be;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule